// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when the rows of a DRAM bank group get refreshed. It keeps count of the refreshes that are due but not yet issued. It asks the command arbiter for a slot and, once a slot is granted, sends out one refresh command that carries the next row address. A free-running tick input marks time. A retention window is a fixed number of ticks, and every row has to be refreshed once within it, including rows that are never read or written.

A mode input chooses how the refresh work is spread over the window.

- **Spread mode:** one refresh falls due in each slice of the window. The slice is the window length divided by the row count. Normal traffic is held back only when too many refreshes have been deferred.
- **Burst mode:** a full sweep of all rows falls due at the end of each window. Traffic is held off until the whole sweep has been issued.

A separate enter/exit pair places the device in self-refresh. In that state the controller stays silent. Leaving it takes a fixed wake-up delay, and a ready flag stays low for the whole delay.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset, `ref_req_o`, `hold_o` and `cmd_vld_o` are 0, `ready_o` is 1, `self_ref_o` is 0 and `cmd_row_o` is 0. The tick counter and the owed-refresh count both start at 0.
- R2: When `mode_i` is 0 (spread mode), each group of RET_TICKS/ROWS accepted ticks adds one owed refresh. `ref_req_o` is high in the cycle after the tick that completes a group, and it stays high while the owed count is non-zero.
- R3: When `mode_i` is 1 (burst mode), the tick that completes RET_TICKS accepted ticks adds ROWS owed refreshes. `hold_o` is high whenever any refresh is owed in burst mode.
- R4: A refresh is issued in every cycle in which both `ref_req_o` and `ref_gnt_i` are high. In the next cycle `cmd_vld_o` is 1 and `cmd_row_o` carries the row address that was used. The row address starts at 0, counts up by one per issue, and wraps from ROWS-1 to 0. `cmd_row_o` keeps its value between issues.
- R5: In spread mode, `hold_o` is high only while more than DEFER_MAX (default 8) refreshes are owed. At DEFER_MAX or fewer owed refreshes, traffic is not held.
- R6: The owed count saturates at ROWS. When grants resume after a long stall, no more than ROWS refreshes are issued to catch up.
- R7: A pulse on `sr_enter_i` while active moves the block into self-refresh. In that state:
  - `self_ref_o` is 1 and `ready_o` is 0;
  - `ref_req_o` and `hold_o` stay 0, and ticks are ignored;
  - the owed count and the tick counter are cleared.
- R8: A pulse on `sr_exit_i` during self-refresh starts the wake-up delay. `ready_o` stays 0 for exactly EXIT_CYC cycles (default 10) and then returns to 1. No refresh is requested during the delay. `sr_exit_i` has no effect while active, and `sr_enter_i` has no effect during the wake-up delay.
- R9: After wake-up, tick counting starts again from 0. In spread mode the first owed refresh follows the RET_TICKS/ROWS-th tick after ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Refresh mode: 0 spread, 1 burst |
| tick_i | input | 1 | Time-base pulse, one per tick |
| sr_enter_i | input | 1 | Request to enter self-refresh |
| sr_exit_i | input | 1 | Request to leave self-refresh |
| ref_gnt_i | input | 1 | Grant from the command arbiter |
| ref_req_o | output | 1 | Refresh slot request to the arbiter |
| hold_o | output | 1 | Hold off normal traffic |
| cmd_vld_o | output | 1 | Refresh command issued this cycle |
| cmd_row_o | output | ROW_W | Row address of the refresh command |
| ready_o | output | 1 | Normal commands are allowed |
| self_ref_o | output | 1 | Device is in self-refresh |

## Verification
The spread mode is first run with the grant always high and a tick every cycle. That shows the one-per-slice cadence and the row wrap without any backlog. The grant is then withheld for many slices, which separates the deferral threshold from the saturation cap. When grants resume, draining the backlog shows the exact catch-up count. Burst mode is run with a grant that arrives on two cycles in three, so the hold must last across the gaps until the whole sweep is done. Self-refresh pulses are sent in every state, including the states where they must be ignored. Ticks keep arriving during self-refresh, which shows that the timer restarts from zero after wake-up.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic {
    MODE_SPREAD = 1'b0,
    MODE_BURST  = 1'b1
  } ref_mode_e;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_SELF   = 2'd1,
    ST_WAKE   = 2'd2
  } pwr_state_e;

  // next owed count: add new work, remove one issued refresh, clip at cap
  function automatic int unsigned owed_step(int unsigned cur, int unsigned add,
                                            logic take, int unsigned cap);
    int unsigned sum;
    sum = cur + add - (take ? 32'd1 : 32'd0);
    return (sum > cap) ? cap : sum;
  endfunction

  // next row address with wrap at rows-1
  function automatic int unsigned row_advance(int unsigned cur, int unsigned rows);
    return (cur + 32'd1 == rows) ? 32'd0 : cur + 32'd1;
  endfunction

  // true when this counter value closes a slice
  function automatic logic slice_end(int unsigned cnt, int unsigned slice);
    return (cnt % slice) == slice - 32'd1;
  endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int unsigned RET_TICKS = 64,
  parameter int unsigned SUB_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic sub_evt,
  output logic period_evt
);
  import refresh_pkg::*;

  localparam int unsigned CW   = (RET_TICKS > 1) ? $clog2(RET_TICKS) : 1;
  localparam int unsigned LAST = RET_TICKS - 1;

  logic [CW-1:0] cnt_q;
  logic          wrap_w;

  assign wrap_w     = (32'(cnt_q) == LAST);
  assign sub_evt    = run & tick & slice_end(32'(cnt_q), SUB_TICKS);
  assign period_evt = run & tick & wrap_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= wrap_w ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/refresh_ledger.sv
module refresh_ledger #(
  parameter int unsigned ROWS = 16,
  parameter int unsigned CW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          add_one,
  input  logic          add_all,
  input  logic          take,
  output logic [CW-1:0] owed
);
  import refresh_pkg::*;

  int unsigned add_w;
  logic [CW-1:0] owed_q;

  always_comb begin
    if (add_all)      add_w = ROWS;
    else if (add_one) add_w = 32'd1;
    else              add_w = 32'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed_q <= '0;
    end else if (clear) begin
      owed_q <= '0;
    end else begin
      owed_q <= CW'(owed_step(32'(owed_q), add_w, take, ROWS));
    end
  end

  assign owed = owed_q;

endmodule

// File: rtl/wake_fsm.sv
module wake_fsm #(
  parameter int unsigned EXIT_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sr_enter,
  input  logic sr_exit,
  output logic active,
  output logic in_self
);
  import refresh_pkg::*;

  localparam int unsigned EW = $clog2(EXIT_CYC + 1);

  pwr_state_e    st_q;
  logic [EW-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_ACTIVE;
      wait_q <= '0;
    end else begin
      unique case (st_q)
        ST_ACTIVE: if (sr_enter) st_q <= ST_SELF;
        ST_SELF: if (sr_exit) begin
          st_q   <= ST_WAKE;
          wait_q <= EW'(EXIT_CYC - 1);
        end
        ST_WAKE: begin
          if (wait_q == '0) st_q <= ST_ACTIVE;
          else              wait_q <= wait_q - 1'b1;
        end
        default: st_q <= ST_ACTIVE;
      endcase
    end
  end

  assign active  = (st_q == ST_ACTIVE);
  assign in_self = (st_q == ST_SELF);

endmodule

// File: rtl/refresh_issuer.sv
module refresh_issuer #(
  parameter int unsigned ROWS = 16,
  parameter int unsigned RW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  output logic          cmd_vld,
  output logic [RW-1:0] cmd_row
);
  import refresh_pkg::*;

  logic [RW-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q   <= '0;
      cmd_vld <= 1'b0;
      cmd_row <= '0;
    end else begin
      cmd_vld <= issue;
      if (issue) begin
        cmd_row <= row_q;
        row_q   <= RW'(row_advance(32'(row_q), ROWS));
      end
    end
  end

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int unsigned ROWS      = 16,
  parameter int unsigned RET_TICKS = 64,
  parameter int unsigned DEFER_MAX = 8,
  parameter int unsigned EXIT_CYC  = 10,
  localparam int unsigned ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             tick_i,
  input  logic             sr_enter_i,
  input  logic             sr_exit_i,
  input  logic             ref_gnt_i,
  output logic             ref_req_o,
  output logic             hold_o,
  output logic             cmd_vld_o,
  output logic [ROW_W-1:0] cmd_row_o,
  output logic             ready_o,
  output logic             self_ref_o
);
  import refresh_pkg::*;

  localparam int unsigned SUB_TICKS = RET_TICKS / ROWS;
  localparam int unsigned OWED_W    = $clog2(ROWS + 1);

  ref_mode_e         mode_w;
  logic              active_w;
  logic              in_self_w;
  logic              sub_evt_w;
  logic              period_evt_w;
  logic              issue_w;
  logic              owed_any_w;
  logic              over_defer_w;
  logic [OWED_W-1:0] owed_w;

  assign mode_w = ref_mode_e'(mode_i);

  wake_fsm #(.EXIT_CYC(EXIT_CYC)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .sr_enter (sr_enter_i),
    .sr_exit  (sr_exit_i),
    .active   (active_w),
    .in_self  (in_self_w)
  );

  refresh_timer #(.RET_TICKS(RET_TICKS), .SUB_TICKS(SUB_TICKS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (active_w),
    .tick       (tick_i),
    .sub_evt    (sub_evt_w),
    .period_evt (period_evt_w)
  );

  refresh_ledger #(.ROWS(ROWS), .CW(OWED_W)) u_ledger (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (!active_w),
    .add_one (sub_evt_w && mode_w == MODE_SPREAD),
    .add_all (period_evt_w && mode_w == MODE_BURST),
    .take    (issue_w),
    .owed    (owed_w)
  );

  refresh_issuer #(.ROWS(ROWS), .RW(ROW_W)) u_issuer (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue_w),
    .cmd_vld (cmd_vld_o),
    .cmd_row (cmd_row_o)
  );

  assign owed_any_w   = (owed_w != '0);
  assign over_defer_w = (32'(owed_w) > DEFER_MAX);
  assign ref_req_o    = active_w & owed_any_w;
  assign issue_w      = ref_req_o & ref_gnt_i;
  assign hold_o       = ref_req_o & ((mode_w == MODE_BURST) | over_defer_w);
  assign ready_o      = active_w;
  assign self_ref_o   = in_self_w;

endmodule

// File: rtl/refresh_chk.sv
module refresh_chk #(
  parameter int unsigned ROWS      = 16,
  parameter int unsigned DEFER_MAX = 8,
  parameter int unsigned CW        = 5,
  parameter int unsigned RW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_burst,
  input logic          req,
  input logic          hold,
  input logic          cmd_vld,
  input logic [RW-1:0] cmd_row,
  input logic          ready,
  input logic          self_ref,
  input logic [CW-1:0] owed,
  input logic          issue
);

  // R4
  cmd_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> $past(issue));

  // R4
  issue_gives_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> cmd_vld);

  // R4
  row_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> (32'(cmd_row) < ROWS));

  // R7
  self_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    self_ref |-> (!req && !hold && !ready));

  // R8
  wake_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !req);

  // R6
  owed_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(owed) <= ROWS);

  // R5
  defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !mode_burst) |-> (32'(owed) > DEFER_MAX));

endmodule

bind dram_refresh_ctrl refresh_chk #(
  .ROWS(ROWS), .DEFER_MAX(DEFER_MAX), .CW(OWED_W), .RW(ROW_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_burst (mode_i),
  .req        (ref_req_o),
  .hold       (hold_o),
  .cmd_vld    (cmd_vld_o),
  .cmd_row    (cmd_row_o),
  .ready      (ready_o),
  .self_ref   (self_ref_o),
  .owed       (owed_w),
  .issue      (issue_w)
);

// File: tb/dram_refresh_ctrl_bench.sv
module dram_refresh_ctrl_bench;
  localparam int ROWS  = 16;
  localparam int RET   = 64;
  localparam int DEFER = 8;
  localparam int EXITC = 10;
  localparam int SUB   = RET / ROWS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0, tick = 1'b0, en = 1'b0, ex = 1'b0, gnt = 1'b0;
  logic       req, hold, cvld, ready, sref;
  logic [3:0] crow;

  int vectors = 0, fails = 0, cyc = 0;
  int tick_every = 0, gnt_mode = 0;
  bit pend_en = 0, pend_ex = 0;
  string cur_tag = "R1";

  // reference state
  int m_state = 0, m_wait = 0, m_tcnt = 0, m_owed = 0, m_row = 0, m_vld = 0, m_crow = 0;

  always #5 clk = ~clk;

  dram_refresh_ctrl u_dram_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .tick_i(tick),
    .sr_enter_i(en), .sr_exit_i(ex), .ref_gnt_i(gnt),
    .ref_req_o(req), .hold_o(hold), .cmd_vld_o(cvld), .cmd_row_o(crow),
    .ready_o(ready), .self_ref_o(sref)
  );

  task automatic chk(bit ok, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int e_req, e_hold;
    e_req  = (m_state == 0 && m_owed > 0) ? 1 : 0;
    e_hold = (e_req == 1 && (mode == 1'b1 || m_owed > DEFER)) ? 1 : 0;
    chk(int'(req) == e_req, "ref_req_o", int'(req), e_req);
    chk(int'(hold) == e_hold, "hold_o", int'(hold), e_hold);
    chk(int'(cvld) == m_vld, "cmd_vld_o", int'(cvld), m_vld);
    chk(int'(crow) == m_crow, "cmd_row_o", int'(crow), m_crow);
    chk(int'(ready) == (m_state == 0 ? 1 : 0), "ready_o", int'(ready), m_state == 0 ? 1 : 0);
    chk(int'(sref) == (m_state == 1 ? 1 : 0), "self_ref_o", int'(sref), m_state == 1 ? 1 : 0);
  endtask

  task automatic model_adv();
    int n_state, n_wait, n_tcnt, n_owed, add;
    bit iss;
    n_state = m_state; n_wait = m_wait;
    iss = (m_state == 0 && m_owed > 0 && gnt);
    m_vld = iss ? 1 : 0;
    if (iss) begin
      m_crow = m_row;
      m_row  = (m_row + 1) % ROWS;
    end
    if (m_state != 0) begin
      n_owed = 0; n_tcnt = 0;
    end else begin
      add = 0;
      if (tick) begin
        if (!mode && (m_tcnt % SUB) == SUB - 1) add = 1;
        if (mode && m_tcnt == RET - 1) add = ROWS;
      end
      n_owed = m_owed + add - (iss ? 1 : 0);
      if (n_owed > ROWS) n_owed = ROWS;
      n_tcnt = tick ? (m_tcnt + 1) % RET : m_tcnt;
    end
    case (m_state)
      0: if (en) n_state = 1;
      1: if (ex) begin n_state = 2; n_wait = EXITC - 1; end
      default: if (m_wait == 0) n_state = 0; else n_wait = m_wait - 1;
    endcase
    m_state = n_state; m_wait = n_wait; m_owed = n_owed; m_tcnt = n_tcnt;
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    cyc++;
    tick = (tick_every != 0 && (cyc % tick_every) == 0);
    case (gnt_mode)
      0: gnt = 1'b0;
      1: gnt = 1'b1;
      default: gnt = ((cyc % 3) != 0);
    endcase
    en = pend_en; ex = pend_ex;
    pend_en = 0; pend_ex = 0;
    model_adv();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    cur_tag = "R1"; run(2);
    // R2 spread cadence, grant always
    cur_tag = "R2"; mode = 1'b0; tick_every = 1; gnt_mode = 1; run(40);
    // R5 grant withheld: backlog crosses the deferral threshold
    cur_tag = "R5"; gnt_mode = 0; run(40);
    // R6 keep withholding until the cap holds
    cur_tag = "R6"; run(50);
    // R4 drain backlog, row wrap
    cur_tag = "R4"; gnt_mode = 1; tick_every = 2; run(40);
    // R3 burst sweep with gapped grant
    cur_tag = "R3"; mode = 1'b1; tick_every = 1; gnt_mode = 2; run(160);
    // R8 exit while active is ignored
    cur_tag = "R8"; pend_ex = 1; run(5);
    // R7 self-refresh, ticks ignored
    cur_tag = "R7"; pend_en = 1; run(30);
    // R8 wake-up delay, enter ignored during wake
    cur_tag = "R8"; pend_ex = 1; run(4); pend_en = 1; run(12);
    // R9 timer restarts after wake
    cur_tag = "R9"; mode = 1'b0; gnt_mode = 1; run(40);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule